// File: doc/BRIEF.md
# Bridge Transaction Ordering Scheduler

This block sits in one direction of a two-bus bridge. It holds the transactions that are waiting to cross and picks which one goes next on the far bus. Each queued transaction belongs to one of five classes: posted write, read request, write request, read completion and write completion. The block does not issue in plain arrival order. It applies a pass/no-pass rule between the classes, and an entry that the far bus retried keeps no fixed place against other retried entries.

Upstream logic pushes a class code with an address and a data word. The scheduler offers one entry at a time on the issue port and keeps one transaction outstanding. A result strobe then reports whether that transaction finished or was retried. A finished entry leaves the queue. A retried entry stays queued and drops behind the entries that have not yet been tried. A retried read or write request or completion also moves to the youngest age, so retried delayed entries take turns. A retried posted write keeps its age, so posted writes still leave in the order they arrived. One slot is held back for posted writes, so a queue full of delayed work never stalls a posted write.

Top module: `bord_sched`

## Requirements
- R1: After reset the queue is empty: `iss_valid` is 0 and `enq_ready` is 1 for every class.
- R2: Posted writes (class code 0) complete in arrival order, even when one of them has been retried.
- R3: A read request (1), write request (2) or read completion (3) is never offered while an older posted write is still queued.
- R4: A write completion (4) may be offered ahead of an older posted write that is still queued.
- R5: A posted write may be offered ahead of an earlier-arrived delayed entry that has been retried.
- R6: On a retry the entry stays queued and is offered again from the next cycle on. Entries that have not been tried are preferred over retried ones. A retried delayed entry moves behind every other queued entry. A retried posted write keeps its age.
- R7: A completed entry leaves the queue. Two writes to the same address stay two separate transactions, each with its own data.
- R8: Only one transaction is outstanding: `iss_valid` stays low from the acceptance cycle until the cycle after `res_valid`.
- R9: A posted write is accepted while at least one slot is free. A delayed class is accepted only while more than `PW_RSV` slots are free. A push that is refused changes nothing.
- R10: A push and a completion in the same cycle both take effect.
- R11: Among the eligible entries of the same kind (all untried, or all retried), the oldest is offered first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enq_valid | input | 1 | Push request |
| enq_ready | output | 1 | Push accepted this cycle, depends on `enq_cls` |
| enq_cls | input | 3 | Class code: 0 posted write, 1 read req, 2 write req, 3 read cpl, 4 write cpl |
| enq_addr | input | ADDR_W | Address of the pushed transaction |
| enq_data | input | DATA_W | Data of the pushed transaction |
| iss_valid | output | 1 | An entry is offered for issue |
| iss_ready | input | 1 | Far bus takes the offered entry |
| iss_cls | output | 3 | Class code of the offered entry |
| iss_addr | output | ADDR_W | Address of the offered entry |
| iss_data | output | DATA_W | Data of the offered entry |
| iss_slot | output | $clog2(DEPTH) | Slot index of the offered entry |
| res_valid | input | 1 | Result of the outstanding transaction |
| res_retry | input | 1 | With `res_valid`: 1 retried, 0 completed |

## Verification
The bench builds the block with eight slots, one slot held back for posted writes and 16-bit address and data. At that size it can fill the queue to every occupancy from one to eight and drain it again. It also reaches both backpressure thresholds, the exact-full case and a push that lands in the same cycle as a completion. Directed mixes of the five classes, with chosen retries, cover every pass and block case of the rule and the turn-taking among retried delayed entries.

// File: rtl/bord_pkg.sv
`timescale 1ns/1ps
package bord_pkg;

    typedef enum logic [2:0] {
        CLS_PW    = 3'd0,
        CLS_RDREQ = 3'd1,
        CLS_WRREQ = 3'd2,
        CLS_RDCPL = 3'd3,
        CLS_WRCPL = 3'd4
    } cls_e;

    // An older entry of class 'elder' holds back a younger entry of class 'junior'.
    function automatic logic holds_back(cls_e elder, cls_e junior);
        return (elder == CLS_PW) && (junior != CLS_WRCPL);
    endfunction

    // Only delayed entries give up their age when retried.
    function automatic logic reages_on_retry(cls_e c);
        return c != CLS_PW;
    endfunction

endpackage

// File: rtl/bord_free_pick.sv
`timescale 1ns/1ps
module bord_free_pick #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0] vld_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [CNT_W-1:0] cnt_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        cnt_o = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
        for (int i = 0; i < DEPTH; i++) begin
            cnt_o = cnt_o + CNT_W'(!vld_i[i]);
        end
    end
endmodule

// File: rtl/bord_arbiter.sv
`timescale 1ns/1ps
module bord_arbiter
    import bord_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DEPTH-1:0] vld_i,
    input  logic [DEPTH-1:0] rty_i,
    input  cls_e             cls_i   [DEPTH],
    input  logic [DEPTH-1:0] older_i [DEPTH],  // row j: entries older than j
    output logic [DEPTH-1:0] grant_o,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    logic [DEPTH-1:0] pw_m, elig, fresh, pool;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) pw_m[i] = vld_i[i] && (cls_i[i] == CLS_PW);
    end

    genvar j;
    generate
        for (j = 0; j < DEPTH; j++) begin : g_slot
            logic blocked;
            always_comb begin
                blocked = 1'b0;
                for (int i = 0; i < DEPTH; i++) begin
                    if (vld_i[i] && older_i[j][i] && holds_back(cls_i[i], cls_i[j]))
                        blocked = 1'b1;
                end
            end
            assign elig[j] = vld_i[j] && !blocked;

            // R3: a granted entry other than a write completion has no older queued posted write
            assert_pw_blocks_R3: assert property (@(posedge clk) disable iff (rst)
                (grant_o[j] && cls_i[j] != CLS_WRCPL) |-> ((older_i[j] & pw_m) == '0));
        end
    endgenerate

    assign fresh = elig & ~rty_i;
    assign pool  = (|fresh) ? fresh : elig;

    always_comb begin
        for (int k = 0; k < DEPTH; k++) grant_o[k] = pool[k] && ((pool & older_i[k]) == '0);
    end

    assign any_o = |grant_o;

    always_comb begin
        idx_o = '0;
        for (int k = 0; k < DEPTH; k++) if (grant_o[k]) idx_o = idx_o | IDX_W'(k);
    end

    assert_single_grant_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o));
    assert_grant_valid_R11: assert property (@(posedge clk) disable iff (rst)
        (grant_o & ~vld_i) == '0);
endmodule

// File: rtl/bord_sched.sv
`timescale 1ns/1ps
module bord_sched
    import bord_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int PW_RSV = 1,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enq_valid,
    output logic              enq_ready,
    input  logic [2:0]        enq_cls,
    input  logic [ADDR_W-1:0] enq_addr,
    input  logic [DATA_W-1:0] enq_data,
    output logic              iss_valid,
    input  logic              iss_ready,
    output logic [2:0]        iss_cls,
    output logic [ADDR_W-1:0] iss_addr,
    output logic [DATA_W-1:0] iss_data,
    output logic [IDX_W-1:0]  iss_slot,
    input  logic              res_valid,
    input  logic              res_retry
);
    logic [DEPTH-1:0]  vld_q, rty_q;
    cls_e              cls_q   [DEPTH];
    logic [ADDR_W-1:0] addr_q  [DEPTH];
    logic [DATA_W-1:0] data_q  [DEPTH];
    logic [DEPTH-1:0]  older_q [DEPTH];
    logic [DEPTH-1:0]  older_d [DEPTH];
    logic              busy_q;
    logic [IDX_W-1:0]  cur_q;

    logic              free_any;
    logic [IDX_W-1:0]  free_idx;
    logic [CNT_W-1:0]  free_cnt;
    logic [DEPTH-1:0]  grant;
    logic              grant_any;
    logic [IDX_W-1:0]  grant_idx;
    logic              enq_fire, acc, done, rtry;
    cls_e              in_cls;
    logic [DEPTH-1:0]  pw_m;

    bord_free_pick #(.DEPTH(DEPTH)) u_free (
        .vld_i (vld_q),
        .any_o (free_any),
        .idx_o (free_idx),
        .cnt_o (free_cnt)
    );

    bord_arbiter #(.DEPTH(DEPTH)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .vld_i   (vld_q),
        .rty_i   (rty_q),
        .cls_i   (cls_q),
        .older_i (older_q),
        .grant_o (grant),
        .any_o   (grant_any),
        .idx_o   (grant_idx)
    );

    assign in_cls    = cls_e'(enq_cls);
    assign enq_ready = free_any &&
                       ((in_cls == CLS_PW) ? 1'b1 : (free_cnt > CNT_W'(PW_RSV)));
    assign enq_fire  = enq_valid && enq_ready;

    assign iss_valid = !busy_q && grant_any;
    assign iss_slot  = grant_idx;
    assign iss_cls   = cls_q[grant_idx];
    assign iss_addr  = addr_q[grant_idx];
    assign iss_data  = data_q[grant_idx];

    assign acc  = iss_valid && iss_ready;
    assign done = busy_q && res_valid && !res_retry;
    assign rtry = busy_q && res_valid && res_retry;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) pw_m[i] = vld_q[i] && (cls_q[i] == CLS_PW);
    end

    // Age matrix update: a retried delayed entry becomes youngest, then a push lands behind it.
    always_comb begin
        for (int r = 0; r < DEPTH; r++) older_d[r] = older_q[r];
        if (rtry && reages_on_retry(cls_q[cur_q])) begin
            for (int r = 0; r < DEPTH; r++) older_d[r][cur_q] = 1'b0;
            older_d[cur_q] = vld_q;
            older_d[cur_q][cur_q] = 1'b0;
        end
        if (enq_fire) begin
            for (int r = 0; r < DEPTH; r++) older_d[r][free_idx] = 1'b0;
            older_d[free_idx] = vld_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= '0;
            rty_q  <= '0;
            busy_q <= 1'b0;
            cur_q  <= '0;
            for (int r = 0; r < DEPTH; r++) older_q[r] <= '0;
        end else begin
            for (int r = 0; r < DEPTH; r++) older_q[r] <= older_d[r];
            if (done) vld_q[cur_q] <= 1'b0;
            if (rtry) rty_q[cur_q] <= 1'b1;
            if (enq_fire) begin
                vld_q[free_idx] <= 1'b1;
                rty_q[free_idx] <= 1'b0;
            end
            if (acc) begin
                busy_q <= 1'b1;
                cur_q  <= grant_idx;
            end else if (busy_q && res_valid) begin
                busy_q <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (enq_fire) begin
            cls_q[free_idx]  <= in_cls;
            addr_q[free_idx] <= enq_addr;
            data_q[free_idx] <= enq_data;
        end
    end

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        (enq_fire && !done) |=> ($countones(vld_q) == $past($countones(vld_q)) + 1));
    assert_push_and_pop_R10: assert property (@(posedge clk) disable iff (rst)
        (enq_fire && done) |=> ($countones(vld_q) == $past($countones(vld_q))));
    assert_retry_keeps_R6: assert property (@(posedge clk) disable iff (rst)
        rtry |=> vld_q[$past(cur_q)]);
    assert_done_removes_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !vld_q[$past(cur_q)]);
    assert_one_outstanding_R8: assert property (@(posedge clk) disable iff (rst)
        acc |=> !iss_valid);
    assert_pw_in_order_R2: assert property (@(posedge clk) disable iff (rst)
        (done && cls_q[cur_q] == CLS_PW) |-> ((older_q[cur_q] & pw_m) == '0));
endmodule

// File: tb/test_bord_sched.sv
`timescale 1ns/1ps
module test_bord_sched;
    localparam int DEPTH = 8;
    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          enq_valid, enq_ready;
    logic [2:0]    enq_cls;
    logic [AW-1:0] enq_addr;
    logic [DW-1:0] enq_data;
    logic          iss_valid, iss_ready;
    logic [2:0]    iss_cls;
    logic [AW-1:0] iss_addr;
    logic [DW-1:0] iss_data;
    logic [$clog2(DEPTH)-1:0] iss_slot;
    logic          res_valid, res_retry;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #4 clk = ~clk;

    bord_sched #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW), .PW_RSV(1)) i_bord_sched (
        .clk(clk), .rst(rst),
        .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_cls(enq_cls),
        .enq_addr(enq_addr), .enq_data(enq_data),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_cls(iss_cls),
        .iss_addr(iss_addr), .iss_data(iss_data), .iss_slot(iss_slot),
        .res_valid(res_valid), .res_retry(res_retry)
    );

    function automatic int dval(input int a);
        return (a * 7 + 3) & 16'hFFFF;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Starts just after a falling edge, ends just after the next one.
    task automatic enq(input logic [2:0] c, input int a, input int d,
                       input bit exp_rdy, input string req);
        enq_valid = 1'b1; enq_cls = c; enq_addr = AW'(a); enq_data = DW'(d);
        #1;
        chk(enq_ready == exp_rdy, req, int'(enq_ready), int'(exp_rdy));
        @(negedge clk);
        enq_valid = 1'b0;
    endtask

    task automatic iss(input int a, input int d, input bit rt, input string req,
                       input bit ld = 1'b0, input int la = 0);
        #1;
        chk(iss_valid == 1'b1, req, int'(iss_valid), 1);
        chk(iss_addr == AW'(a), req, int'(iss_addr), a);
        chk(iss_data == DW'(d), req, int'(iss_data), d);
        iss_ready = 1'b1;
        @(negedge clk);
        iss_ready = 1'b0;
        #1;
        chk(iss_valid == 1'b0, "R8", int'(iss_valid), 0);
        res_valid = 1'b1; res_retry = rt;
        if (ld) begin
            enq_valid = 1'b1; enq_cls = 3'd0; enq_addr = AW'(la); enq_data = DW'(dval(la));
            #1;
            chk(enq_ready == 1'b1, "R10", int'(enq_ready), 1);
        end
        @(negedge clk);
        res_valid = 1'b0; res_retry = 1'b0; enq_valid = 1'b0;
    endtask

    task automatic expect_empty(input string req);
        #1;
        chk(iss_valid == 1'b0, req, int'(iss_valid), 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; enq_valid = 1'b0; enq_cls = 3'd1; enq_addr = '0; enq_data = '0;
        iss_ready = 1'b0; res_valid = 1'b0; res_retry = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: empty after reset, delayed class accepted
        #1;
        chk(iss_valid == 1'b0, "R1", int'(iss_valid), 0);
        chk(enq_ready == 1'b1, "R1", int'(enq_ready), 1);
        enq_cls = 3'd0; #1;
        chk(enq_ready == 1'b1, "R1", int'(enq_ready), 1);
        @(negedge clk);

        // R7/R2/R11: same-address writes kept apart, then oldest eligible first
        enq(3'd0, 'h01, 'h1111, 1'b1, "R9");
        enq(3'd0, 'h01, 'h2222, 1'b1, "R9");
        enq(3'd1, 'h02, dval('h02), 1'b1, "R9");
        enq(3'd0, 'h03, dval('h03), 1'b1, "R9");
        iss('h01, 'h1111, 1'b0, "R7");
        iss('h01, 'h2222, 1'b0, "R7");
        iss('h02, dval('h02), 1'b0, "R11");
        iss('h03, dval('h03), 1'b0, "R2");
        expect_empty("R7");

        // R3/R4/R6: retried posted write blocks RDCPL/RDREQ, WRCPL passes it
        enq(3'd0, 'h10, dval('h10), 1'b1, "R9");
        enq(3'd3, 'h11, dval('h11), 1'b1, "R9");
        enq(3'd4, 'h12, dval('h12), 1'b1, "R9");
        enq(3'd1, 'h13, dval('h13), 1'b1, "R9");
        iss('h10, dval('h10), 1'b1, "R6");
        iss('h12, dval('h12), 1'b0, "R4");
        iss('h10, dval('h10), 1'b0, "R3");
        iss('h11, dval('h11), 1'b0, "R3");
        iss('h13, dval('h13), 1'b0, "R11");
        expect_empty("R7");

        // R5/R6: retried delayed entries drop behind and take turns
        enq(3'd1, 'h20, dval('h20), 1'b1, "R9");
        enq(3'd2, 'h21, dval('h21), 1'b1, "R9");
        enq(3'd0, 'h22, dval('h22), 1'b1, "R9");
        iss('h20, dval('h20), 1'b1, "R6");
        iss('h21, dval('h21), 1'b1, "R6");
        iss('h22, dval('h22), 1'b0, "R5");
        iss('h20, dval('h20), 1'b1, "R6");
        iss('h21, dval('h21), 1'b0, "R6");
        iss('h20, dval('h20), 1'b0, "R6");
        expect_empty("R7");

        // R2: posted-write order at every occupancy
        for (int n = 1; n <= DEPTH; n++) begin
            for (int k = 0; k < n; k++) enq(3'd0, 'h100 + 16 * n + k, dval('h100 + 16 * n + k), 1'b1, "R9");
            for (int k = 0; k < n; k++) iss('h100 + 16 * n + k, dval('h100 + 16 * n + k), 1'b0, "R2");
            expect_empty("R2");
        end

        // R9: reserve slot for posted writes, exact-full refusal
        for (int k = 0; k < DEPTH - 1; k++) enq(3'd1, 'h30 + k, dval('h30 + k), 1'b1, "R9");
        enq(3'd2, 'h3F, dval('h3F), 1'b0, "R9");
        enq(3'd0, 'h37, dval('h37), 1'b1, "R9");
        enq(3'd0, 'h38, dval('h38), 1'b0, "R9");
        iss('h30, dval('h30), 1'b0, "R11");
        // R10: push lands in the completion cycle
        iss('h31, dval('h31), 1'b0, "R11", 1'b1, 'h40);
        enq_cls = 3'd1; #1;
        chk(enq_ready == 1'b0, "R10", int'(enq_ready), 0);
        enq_cls = 3'd0; #1;
        chk(enq_ready == 1'b1, "R10", int'(enq_ready), 1);
        @(negedge clk);
        for (int k = 2; k < DEPTH - 1; k++) iss('h30 + k, dval('h30 + k), 1'b0, "R11");
        iss('h37, dval('h37), 1'b0, "R9");
        iss('h40, dval('h40), 1'b0, "R10");
        expect_empty("R9");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule